// File: doc/BRIEF.md
# UART Receive Character-Timeout Interrupt Generator

This block raises the character-timeout interrupt of a 16550-style UART receiver. It watches the receive FIFO fill level, the pulses that mark a character being stored and a character being read by software, and a 16x baud tick. A down-counter is loaded with four character times, expressed in 16x ticks, and counts toward zero. When the counter has run out, the interrupt request is raised. Two conditions must also hold: the receive-data interrupt is enabled, and the FIFO holds at least one character.

The FIFO-occupancy condition matters for software. An interrupt handler that reads the holding register only when the line status reports data would never clear a timeout raised with an empty FIFO. For that reason, an idle receiver with nothing buffered never requests this interrupt. While the FIFO is empty the counter is pinned at its reload value, so the first character after an idle period always gets a full four-character window.

The counter runs in a three-state machine. IDLE means the FIFO is empty and the counter is held at reload. COUNT means characters are present and the counter is running. EXPIRED means the counter sits at zero. The transitions are:
- any state to IDLE when the FIFO is empty;
- any state to COUNT on a push or a read;
- IDLE or COUNT to COUNT on a tick that leaves the counter nonzero;
- IDLE or COUNT to EXPIRED on the tick that takes it from one to zero.

EXPIRED otherwise holds its state.

Top module: `uart_rx_timeout_irq`

## Requirements
- R1: The reload value is 64 × (1 start + word bits + parity bit + stop bits) ticks. The word-length code `word_len` maps 0, 1, 2, 3 to 5, 6, 7, 8 data bits, `parity_on`=1 adds one bit, and `two_stop`=1 selects two stop bits instead of one. After a push into a non-empty FIFO with the tick held high, `timeout_irq` is low after reload−1 ticks and high after reload ticks.
- R2: The counter decrements only on cycles where `tick16x` is high and it is nonzero. With `tick16x` low it does not move. Once at zero it stays there, and the interrupt stays asserted.
- R3: `timeout_irq` is high only while `rda_irq_en` is 1. Clearing the enable drops the request in the same cycle, and setting it again with an expired counter raises the request in the same cycle.
- R4: `timeout_irq` is high only while `rx_fifo_count` is nonzero. A FIFO that drains to zero drops the request in the same cycle, and an empty FIFO never raises it, however many ticks pass.
- R5: While `rx_fifo_count` is zero the counter is held at the reload value. A first character, even one with no push pulse seen, needs the full reload count of ticks before the request rises.
- R6: A `rx_push` pulse while the FIFO is non-empty reloads the counter. This restarts the full window even partway through a countdown.
- R7: A `rx_read` pulse masks `timeout_irq` in the cycle it is high and reloads the counter, taking priority over a simultaneous tick. The request then stays low for a full reload window.
- R8: Synchronous active-high `rst` deasserts `timeout_irq` and loads the counter with the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_fifo_count | input | FIFO_CNT_W (5) | Receive FIFO occupancy |
| rx_push | input | 1 | One-cycle pulse per character stored in the FIFO |
| rx_read | input | 1 | One-cycle pulse per software read of the holding register |
| rda_irq_en | input | 1 | Receive-data-available interrupt enable |
| word_len | input | 2 | Data bits minus five |
| parity_on | input | 1 | Parity bit present |
| two_stop | input | 1 | Two stop bits when 1, one when 0 |
| tick16x | input | 1 | 16x baud tick, one cycle wide |
| timeout_irq | output | 1 | Level-sensitive character-timeout interrupt request |

## Verification
Two cases put functions into the same cycle.

The first is a software read that lands while the request is already high and a baud tick is also present. The bench drives `rx_read` and `tick16x` together on the same edge. It judges that the request falls in that very cycle, that the reload beats the decrement, and that a full reload window of ticks is then needed before the request comes back.

The second is the FIFO draining, or the enable clearing, while the counter sits at zero. Here the request must drop combinationally in the same cycle and must not wait for the next edge.

// File: rtl/uart_tmo_pkg.sv
package uart_tmo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } tmo_state_e;

    localparam int START_BITS     = 1;
    localparam int MIN_WORD_BITS  = 5;

endpackage

// File: rtl/uart_tmo_char_time.sv
module uart_tmo_char_time #(
    parameter int CNT_W         = 10,
    parameter int TICKS_PER_BIT = 16,
    parameter int CHAR_TIMES    = 4
) (
    input  logic [1:0]       word_len,
    input  logic             parity_on,
    input  logic             two_stop,
    output logic [CNT_W-1:0] reload_val
);
    import uart_tmo_pkg::*;

    localparam int TICKS_PER_FRAME_BIT = TICKS_PER_BIT * CHAR_TIMES;

    logic [CNT_W-1:0] frame_bits;

    always_comb begin
        frame_bits = CNT_W'(START_BITS + MIN_WORD_BITS)
                   + CNT_W'(word_len)
                   + CNT_W'(parity_on)
                   + (two_stop ? CNT_W'(2) : CNT_W'(1));
        reload_val = frame_bits * CNT_W'(TICKS_PER_FRAME_BIT);
    end

endmodule

// File: rtl/uart_tmo_fsm.sv
module uart_tmo_fsm #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_empty,
    input  logic             reload_req,
    input  logic             tick16x,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expired
);
    import uart_tmo_pkg::*;

    tmo_state_e       state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        if (fifo_empty) begin
            nxt_state = ST_IDLE;
            nxt_cnt   = reload_val;
        end else if (reload_req) begin
            nxt_state = ST_COUNT;
            nxt_cnt   = reload_val;
        end else begin
            unique case (state)
                ST_IDLE, ST_COUNT: begin
                    if (tick16x) begin
                        nxt_cnt   = cnt - CNT_W'(1);
                        nxt_state = (cnt == CNT_W'(1)) ? ST_EXPIRED : ST_COUNT;
                    end
                end
                ST_EXPIRED: begin
                    nxt_state = ST_EXPIRED;
                end
                default: begin
                    nxt_state = ST_IDLE;
                    nxt_cnt   = reload_val;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= reload_val;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    always_comb begin
        expired = (state == ST_EXPIRED);
    end

    assert_state_matches_count_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXPIRED) == (cnt == '0));

    assert_hold_at_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !fifo_empty && !reload_req) |=> (cnt == '0));

    assert_step_down_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && tick16x && !fifo_empty && !reload_req) |=> (cnt == CNT_W'($past(cnt) - CNT_W'(1))));

    assert_no_tick_no_move_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick16x && !fifo_empty && !reload_req) |=> $stable(cnt));

    assert_empty_pins_reload_R5: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |=> (cnt == $past(reload_val)));

    assert_reload_on_event_R6: assert property (@(posedge clk) disable iff (rst)
        (reload_req && !fifo_empty) |=> (cnt == $past(reload_val) && state == ST_COUNT));

endmodule

// File: rtl/uart_tmo_qualify.sv
module uart_tmo_qualify (
    input  logic expired,
    input  logic rda_irq_en,
    input  logic fifo_nonempty,
    input  logic rx_read,
    output logic irq
);
    always_comb begin
        irq = expired && rda_irq_en && fifo_nonempty && !rx_read;
    end
endmodule

// File: rtl/uart_rx_timeout_irq.sv
module uart_rx_timeout_irq #(
    parameter int FIFO_CNT_W    = 5,
    parameter int CNT_W         = 10,
    parameter int TICKS_PER_BIT = 16,
    parameter int CHAR_TIMES    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [FIFO_CNT_W-1:0] rx_fifo_count,
    input  logic                  rx_push,
    input  logic                  rx_read,
    input  logic                  rda_irq_en,
    input  logic [1:0]            word_len,
    input  logic                  parity_on,
    input  logic                  two_stop,
    input  logic                  tick16x,
    output logic                  timeout_irq
);
    logic [CNT_W-1:0] reload_val;
    logic             fifo_nonempty;
    logic             expired;

    always_comb begin
        fifo_nonempty = |rx_fifo_count;
    end

    uart_tmo_char_time #(
        .CNT_W         (CNT_W),
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .CHAR_TIMES    (CHAR_TIMES)
    ) u_char_time (
        .word_len   (word_len),
        .parity_on  (parity_on),
        .two_stop   (two_stop),
        .reload_val (reload_val)
    );

    uart_tmo_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (!fifo_nonempty),
        .reload_req (rx_push || rx_read),
        .tick16x    (tick16x),
        .reload_val (reload_val),
        .expired    (expired)
    );

    uart_tmo_qualify u_qualify (
        .expired       (expired),
        .rda_irq_en    (rda_irq_en),
        .fifo_nonempty (fifo_nonempty),
        .rx_read       (rx_read),
        .irq           (timeout_irq)
    );

    assert_enable_gate_R3: assert property (@(posedge clk) disable iff (rst)
        timeout_irq |-> rda_irq_en);

    assert_nonempty_gate_R4: assert property (@(posedge clk) disable iff (rst)
        timeout_irq |-> (rx_fifo_count != '0));

    assert_read_restarts_R7: assert property (@(posedge clk) disable iff (rst)
        rx_read |=> !timeout_irq);

    assert_push_restarts_R6: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> !timeout_irq);

endmodule

// File: tb/test_uart_rx_timeout_irq.sv
module test_uart_rx_timeout_irq;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] rx_fifo_count;
    logic       rx_push, rx_read, rda_irq_en, parity_on, two_stop, tick16x;
    logic [1:0] word_len;
    logic       timeout_irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    uart_rx_timeout_irq i_uart_rx_timeout_irq (
        .clk           (clk),
        .rst           (rst),
        .rx_fifo_count (rx_fifo_count),
        .rx_push       (rx_push),
        .rx_read       (rx_read),
        .rda_irq_en    (rda_irq_en),
        .word_len      (word_len),
        .parity_on     (parity_on),
        .two_stop      (two_stop),
        .tick16x       (tick16x),
        .timeout_irq   (timeout_irq)
    );

    // {word_len[1:0], parity_on, two_stop, expected reload[9:0]}
    localparam logic [13:0] VEC [8] = '{
        {2'd0, 1'b0, 1'b0, 10'd448},
        {2'd1, 1'b0, 1'b0, 10'd512},
        {2'd2, 1'b0, 1'b0, 10'd576},
        {2'd3, 1'b0, 1'b0, 10'd640},
        {2'd3, 1'b1, 1'b0, 10'd704},
        {2'd3, 1'b1, 1'b1, 10'd768},
        {2'd0, 1'b1, 1'b1, 10'd576},
        {2'd1, 1'b0, 1'b1, 10'd576}
    };

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: timeout_irq=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_ticks(input int n);
        tick16x = 1'b1;
        repeat (n) @(negedge clk);
        tick16x = 1'b0;
    endtask

    task automatic pulse_push();
        rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; rx_fifo_count = 5'd3; rx_push = 1'b0; rx_read = 1'b0;
        rda_irq_en = 1'b1; word_len = 2'd3; parity_on = 1'b0; two_stop = 1'b0;
        tick16x = 1'b0;
        repeat (3) @(negedge clk);
        check(timeout_irq, 1'b0, "R8 reset deasserts");
        rst = 1'b0;
        // R8: counter starts at reload (640 for 8N1)
        run_ticks(639);
        check(timeout_irq, 1'b0, "R8 reload after reset, one tick short");
        run_ticks(1);
        check(timeout_irq, 1'b1, "R8 reload after reset, expiry");

        // R1: table of line settings
        foreach (VEC[i]) begin
            rx_fifo_count = 5'd0;
            {word_len, parity_on, two_stop} = VEC[i][13:10];
            @(negedge clk);
            rx_fifo_count = 5'd1;
            pulse_push();
            run_ticks(int'(VEC[i][9:0]) - 1);
            check(timeout_irq, 1'b0, "R1 one tick before expiry");
            run_ticks(1);
            check(timeout_irq, 1'b1, "R1 expiry at reload ticks");
        end

        // back to 8N1 = 640
        word_len = 2'd3; parity_on = 1'b0; two_stop = 1'b0;
        @(negedge clk);

        // R2: hold at zero
        run_ticks(50);
        check(timeout_irq, 1'b1, "R2 stays asserted at zero");

        // R3: enable gate, same cycle
        rda_irq_en = 1'b0; #1;
        check(timeout_irq, 1'b0, "R3 enable clear drops request");
        @(negedge clk);
        rda_irq_en = 1'b1; #1;
        check(timeout_irq, 1'b1, "R3 enable set re-raises request");
        @(negedge clk);

        // R7: read with simultaneous tick
        rx_read = 1'b1; tick16x = 1'b1; #1;
        check(timeout_irq, 1'b0, "R7 read masks same cycle");
        @(negedge clk);
        rx_read = 1'b0; tick16x = 1'b0;
        check(timeout_irq, 1'b0, "R7 low after read");
        run_ticks(639);
        check(timeout_irq, 1'b0, "R7 full window after read");
        run_ticks(1);
        check(timeout_irq, 1'b1, "R7 expiry after read window");

        // R4: drain drops request same cycle, empty never raises
        rx_fifo_count = 5'd0; #1;
        check(timeout_irq, 1'b0, "R4 drain drops request");
        @(negedge clk);
        run_ticks(2000);
        check(timeout_irq, 1'b0, "R4 empty FIFO never raises");

        // R5: first character without push pulse gets full window
        rx_fifo_count = 5'd2;
        run_ticks(639);
        check(timeout_irq, 1'b0, "R5 first character, one tick short");
        run_ticks(1);
        check(timeout_irq, 1'b1, "R5 first character expiry");

        // R6: push partway restarts window
        pulse_push();
        run_ticks(300);
        pulse_push();
        run_ticks(639);
        check(timeout_irq, 1'b0, "R6 push restarts window");
        run_ticks(1);
        check(timeout_irq, 1'b1, "R6 expiry after restart");

        // R2: no tick, no movement
        pulse_push();
        repeat (1000) @(negedge clk);
        check(timeout_irq, 1'b0, "R2 idle ticks do not expire");
        run_ticks(639);
        check(timeout_irq, 1'b0, "R2 counter did not move without tick");
        run_ticks(1);
        check(timeout_irq, 1'b1, "R2 expiry after ticks resume");

        summary();
        $finish;
    end

endmodule